// File: doc/BRIEF.md
# Edge Event Timestamp Capture

This block watches one asynchronous digital line. It brings the line into the clock domain through a chain of flops, then detects transitions on it. Each transition of the selected kind causes one timestamp to be written into an external buffer. The timestamps come from a free-running counter that restarts at zero whenever software arms the block.

A three-bit mode input selects which events are recorded:
- every transition;
- falling transitions only;
- rising transitions only;
- one rising transition out of four;
- one rising transition out of sixteen.

At arm time the block also latches the synchronised level of the line. With that level, a list of every-transition timestamps can be turned back into a waveform by flipping the level at each stamp.

The block counts the records it has written. When that count reaches the buffer depth, recording stops and a full flag rises, and the block stays this way until the next arm. Each record leaves the block as a single-cycle write strobe, together with an address (the record's index) and the timestamp.

Top module: `edge_stamp_capture`

## Requirements
- R1: `mode` encodes 0 = off, 1 = both edges, 2 = falling, 3 = rising, 4 = every 4th rising, 5 = every 16th rising. Codes 0, 6 and 7 write nothing, and `event_count` holds its value under them.
- R2: In mode 1, every transition of the synchronised input produces exactly one write, including transitions on consecutive cycles.
- R3: In mode 2, only high-to-low transitions produce writes.
- R4: In mode 3, only low-to-high transitions produce writes.
- R5: In mode 4, rising transitions are counted from zero at arm time. The 4th, 8th, 12th and later multiples of four each produce a write.
- R6: In mode 5, the same counting applies, and the 16th, 32nd and later multiples of sixteen each produce a write.
- R7: The timestamp counter is STAMP_W bits wide, where STAMP_W is 16 or 32. It reads 0 in the cycle after `arm`, then increments by one every cycle and wraps modulo 2^STAMP_W.
- R8: `arm_level` takes the synchronised input level present in the cycle `arm` is high.
- R9: Latency and write contents are as follows. A change on `sig_in` before clock edge E0 is seen by the edge detector after E1, and the write appears after E2. In the cycle it is seen, `wr_en` is high for one cycle with `wr_addr` equal to the count before the write and `wr_data` equal to the timestamp counter value.
- R10: When `event_count` reaches BUF_DEPTH, `full` goes high and further events are ignored. `arm` clears `full` and `event_count` and restarts recording.
- R11: After reset, `wr_en`, `event_count`, `full` and `arm_level` are 0. No write happens until the block has been armed once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse: clear counters, latch level, start recording |
| mode | input | 3 | Event selection code (see R1) |
| sig_in | input | 1 | Asynchronous digital input |
| wr_en | output | 1 | One-cycle buffer write strobe |
| wr_addr | output | $clog2(BUF_DEPTH) | Buffer slot of the record |
| wr_data | output | STAMP_W | Timestamp of the record |
| event_count | output | $clog2(BUF_DEPTH+1) | Records written since arm |
| full | output | 1 | Count reached BUF_DEPTH |
| arm_level | output | 1 | Synchronised input level latched at arm |

## Verification
The bench builds the block with STAMP_W = 16 and BUF_DEPTH = 8. The 16-bit counter means a single idle stretch of about 70,000 cycles carries the timestamp across its wrap point within the run time. A depth of 8 lets a burst of one-cycle toggles fill the buffer and then strike the full condition with events still arriving. Both prescaler modes are driven past their first and second emission, so the prescaler's restart at arm time is visible.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic [2:0] {
      MODE_OFF    = 3'd0,
      MODE_BOTH   = 3'd1,
      MODE_FALL   = 3'd2,
      MODE_RISE   = 3'd3,
      MODE_RISE4  = 3'd4,
      MODE_RISE16 = 3'd5
   } esc_mode_e;

   localparam int ESC_DIV_LO = 4;
   localparam int ESC_DIV_HI = 16;
endpackage

// File: rtl/esc_sync.sv
module esc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2) else $error("esc_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/esc_edge_sel.sv
module esc_edge_sel
   import esc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      enable,
   input  esc_mode_e mode,
   input  logic      lvl,
   output logic      hit
);
   localparam int PRE_W = $clog2(ESC_DIV_HI);
   localparam int LO_W  = $clog2(ESC_DIV_LO);

   logic             lvl_prev;
   logic [PRE_W-1:0] pre_q;
   logic             rise, fall, pre_mode, lo_tick, hi_tick;

   assign rise     = lvl & ~lvl_prev;
   assign fall     = ~lvl & lvl_prev;
   assign pre_mode = (mode == MODE_RISE4) || (mode == MODE_RISE16);
   assign lo_tick  = &pre_q[LO_W-1:0];
   assign hi_tick  = &pre_q;

   always_comb begin
      hit = 1'b0;
      if (enable) begin
         case (mode)
            MODE_BOTH:   hit = rise | fall;
            MODE_FALL:   hit = fall;
            MODE_RISE:   hit = rise;
            MODE_RISE4:  hit = rise & lo_tick;
            MODE_RISE16: hit = rise & hi_tick;
            default:     hit = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= 1'b0;
         pre_q    <= '0;
      end else begin
         lvl_prev <= lvl;
         if (clr)                           pre_q <= '0;
         else if (enable && pre_mode && rise) pre_q <= pre_q + 1'b1;
      end
   end

   // R2: a record is only ever raised on a level change
   p_hit_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (lvl != lvl_prev));
   // R5: prescaled hits only on rising edges
   p_prescale_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && pre_mode) |-> rise);
endmodule

// File: rtl/esc_stamp_ctr.sv
module esc_stamp_ctr #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [WIDTH-1:0] value
);
   generate
      if (WIDTH == 16) begin : g_narrow
         logic [15:0] cnt16;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt16 <= '0;
            else if (clr) cnt16 <= '0;
            else          cnt16 <= cnt16 + 16'd1;
         end
         assign value = cnt16;
      end else begin : g_wide
         logic [31:0] cnt32;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt32 <= '0;
            else if (clr) cnt32 <= '0;
            else          cnt32 <= cnt32 + 32'd1;
         end
         assign value = cnt32[WIDTH-1:0];
      end
   endgenerate

   // R7: arming restarts the time base at zero
   p_clear_on_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (value == '0));
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
   import esc_pkg::*;
#(
   parameter int STAMP_W     = 32,
   parameter int BUF_DEPTH   = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W  = $clog2(BUF_DEPTH + 1),
   localparam int ADDR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [2:0]        mode,
   input  logic              sig_in,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [STAMP_W-1:0] wr_data,
   output logic [CNT_W-1:0]  event_count,
   output logic              full,
   output logic              arm_level
);
   initial assert (STAMP_W == 16 || STAMP_W == 32)
      else $error("edge_stamp_capture: STAMP_W must be 16 or 32");
   initial assert (BUF_DEPTH >= 2)
      else $error("edge_stamp_capture: BUF_DEPTH must be at least 2");

   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BUF_DEPTH - 1);

   esc_mode_e          mode_e;
   logic               lvl, hit, active, armed;
   logic [STAMP_W-1:0] stamp;

   assign mode_e = esc_mode_e'(mode);
   assign active = armed & ~full & ~arm & (mode_e != MODE_OFF);

   esc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(sig_in), .q(lvl));

   esc_edge_sel i_edge (
      .clk(clk), .rst_n(rst_n), .clr(arm), .enable(active),
      .mode(mode_e), .lvl(lvl), .hit(hit));

   esc_stamp_ctr #(.WIDTH(STAMP_W)) i_stamp (
      .clk(clk), .rst_n(rst_n), .clr(arm), .value(stamp));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         full        <= 1'b0;
         arm_level   <= 1'b0;
         event_count <= '0;
         wr_en       <= 1'b0;
         wr_addr     <= '0;
         wr_data     <= '0;
      end else if (arm) begin
         armed       <= 1'b1;
         full        <= 1'b0;
         arm_level   <= lvl;
         event_count <= '0;
         wr_en       <= 1'b0;
      end else begin
         wr_en <= hit;
         if (hit) begin
            wr_addr     <= event_count[ADDR_W-1:0];
            wr_data     <= stamp;
            event_count <= event_count + 1'b1;
            if (event_count == LAST_SLOT) full <= 1'b1;
         end
      end
   end

   // R10: nothing is written once the buffer is full
   p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> !wr_en);
   // R10: count never passes the depth
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      event_count <= CNT_W'(BUF_DEPTH));
   // R1: off mode leaves the count untouched
   p_off_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 && !arm) |=> $stable(event_count));
   // R9: the written slot is the one just counted
   p_addr_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (event_count == CNT_W'(wr_addr) + 1'b1));
endmodule

// File: tb/test_edge_stamp_capture.sv
module test_edge_stamp_capture;
   localparam int CLK_T   = 10;
   localparam int STAMP_W = 16;
   localparam int DEPTH   = 8;
   localparam int CNT_W   = $clog2(DEPTH + 1);
   localparam int ADDR_W  = $clog2(DEPTH);
   localparam longint SMASK = (64'd1 << STAMP_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, sig_in = 1'b0;
   logic [2:0] mode = 3'd0;
   logic wr_en, full, arm_level;
   logic [ADDR_W-1:0] wr_addr;
   logic [STAMP_W-1:0] wr_data;
   logic [CNT_W-1:0] event_count;

   int errors = 0, checks = 0;
   string cur_req = "R11";
   bit done = 0;

   edge_stamp_capture #(.STAMP_W(STAMP_W), .BUF_DEPTH(DEPTH)) i_edge_stamp_capture (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .sig_in(sig_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .event_count(event_count), .full(full), .arm_level(arm_level));

   always #(CLK_T/2) clk = ~clk;

   // behavioural reference
   bit m_s1, m_s2, m_prev, m_armed, m_full, m_lvl, m_wr;
   int m_cnt, m_pre, m_addr;
   longint m_stamp, m_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_armed = 0; m_full = 0; m_lvl = 0;
         m_wr = 0; m_cnt = 0; m_pre = 0; m_addr = 0; m_stamp = 0; m_data = 0;
      end else begin
         bit rise, fall, act, hit;
         longint old_stamp;
         rise = m_s2 && !m_prev;
         fall = !m_s2 && m_prev;
         old_stamp = m_stamp;
         if (arm) begin
            m_stamp = 0; m_cnt = 0; m_full = 0; m_pre = 0; m_armed = 1;
            m_lvl = m_s2; m_wr = 0;
         end else begin
            m_stamp = (m_stamp + 1) & SMASK;
            act = m_armed && !m_full && mode >= 1 && mode <= 5;
            hit = 0;
            if (act) begin
               case (mode)
                  3'd1: hit = rise || fall;
                  3'd2: hit = fall;
                  3'd3: hit = rise;
                  3'd4: hit = rise && (m_pre % 4 == 3);
                  3'd5: hit = rise && (m_pre == 15);
                  default: hit = 0;
               endcase
               if (rise && (mode == 3'd4 || mode == 3'd5)) m_pre = (m_pre + 1) % 16;
            end
            m_wr = hit;
            if (hit) begin
               m_addr = m_cnt; m_data = old_stamp; m_cnt++;
               if (m_cnt == DEPTH) m_full = 1;
            end
         end
         m_prev = m_s2; m_s2 = m_s1; m_s1 = sig_in;
      end
   end

   task automatic chk(string req, string what, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk(cur_req, "wr_en", wr_en, m_wr);
      chk(cur_req, "event_count", event_count, m_cnt);
      chk(cur_req, "full", full, m_full);
      chk(cur_req, "arm_level", arm_level, m_lvl);
      if (m_wr) begin
         chk(cur_req, "wr_addr", wr_addr, m_addr);
         chk(cur_req, "wr_data", wr_data, m_data);
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic do_arm();
      arm = 1; tick(1); arm = 0; tick(1);
   endtask
   task automatic pulses(int n, int w);
      for (int i = 0; i < n; i++) begin
         sig_in = 1; tick(w); sig_in = 0; tick(w);
      end
      tick(4);
   endtask

   initial begin
      #(CLK_T * 190000);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      chk("R11", "wr_en reset", wr_en, 0);
      chk("R11", "count reset", event_count, 0);
      chk("R11", "full reset", full, 0);
      rst_n = 1; tick(2);
      cur_req = "R11"; mode = 3'd1; pulses(3, 3);
      chk("R11", "no write before arm", event_count, 0);

      cur_req = "R8"; sig_in = 1; tick(5); do_arm();
      chk("R8", "level latched high", arm_level, 1);
      sig_in = 0; tick(5); do_arm();
      chk("R8", "level latched low", arm_level, 0);

      cur_req = "R2"; mode = 3'd1; pulses(3, 4);
      chk("R2", "both-edge count", event_count, 6);

      cur_req = "R3"; do_arm(); mode = 3'd2; pulses(3, 3);
      chk("R3", "falling count", event_count, 3);

      cur_req = "R4"; do_arm(); mode = 3'd3; pulses(2, 5);
      chk("R4", "rising count", event_count, 2);

      cur_req = "R5"; do_arm(); mode = 3'd4; pulses(9, 2);
      chk("R5", "div4 count", event_count, 2);
      do_arm(); pulses(3, 2);
      chk("R5", "prescaler restarts at arm", event_count, 0);

      cur_req = "R6"; do_arm(); mode = 3'd5; pulses(33, 2);
      chk("R6", "div16 count", event_count, 2);

      cur_req = "R1"; do_arm(); mode = 3'd3; pulses(1, 3);
      mode = 3'd0; pulses(3, 3);
      chk("R1", "off holds count", event_count, 1);
      mode = 3'd7; pulses(3, 3);
      chk("R1", "code 7 holds count", event_count, 1);

      cur_req = "R9"; do_arm(); mode = 3'd1;
      for (int i = 0; i < 6; i++) begin sig_in = ~sig_in; tick(1); end
      tick(4);
      chk("R9", "back-to-back writes", event_count, 6);

      cur_req = "R10"; do_arm();
      for (int i = 0; i < 14; i++) begin sig_in = ~sig_in; tick(1); end
      tick(4);
      chk("R10", "full raised", full, 1);
      chk("R10", "count capped", event_count, DEPTH);
      do_arm();
      chk("R10", "arm clears full", full, 0);

      cur_req = "R7"; sig_in = 0; tick(3); do_arm(); mode = 3'd3;
      tick(70000); pulses(1, 3);
      chk("R7", "event after wrap", event_count, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule